// File: doc/BRIEF.md
# Instruction Step Check and Retirement Trace Unit

This block sits at the front of a single-issue core's step loop. For each step it takes one 32-bit instruction word, fetched by the caller from the PC that the block shows on `cur_pc`, and checks that PC for fetch alignment. It classifies the word as a full-length or compressed instruction and works out the sequential next PC. It then builds one retirement trace record, which is handed out on a valid/ready channel. A trap or branch redirect can override the next PC through an optional input. The record holds:

- the retirement order,
- the PC before and after the step,
- the raw instruction bits,
- both source register addresses and the values read at them.

Decoding is done elsewhere and reported on `dec_valid`. The block drives the two register-file read indices straight from fixed bit fields of the incoming word. It does this whether or not the instruction really uses those registers. A pending enabled interrupt has priority over fetch, and while one is pending no instruction is taken. The block keeps two counters: a retirement counter that feeds the order field, and a step counter.

Top module: `step_trace_unit`

## Requirements
- R1: After reset `cur_pc` is 0x1000, `pkt_valid` is 0, every packet data field and `pkt_trap` are 0, and `step_count` is 0.
- R2: An instruction is misaligned when PC bit 0 is 1, or when PC bit 1 is 1 while `cfg_cmp_en` is 0. A misaligned step gives a packet with `pkt_trap`=1 and `pkt_pc_rdata` equal to the PC. In that packet `pkt_insn`, both register addresses and both read-data fields are 0. The step counter and the retirement counter are left unchanged, and the PC keeps its value unless a redirect is given.
- R3: A word whose bits 1:0 are both 1 is full length, and the next PC is PC+4. Any other value of bits 1:0 makes it compressed, and the next PC is PC+2. Without a redirect, `pkt_pc_wdata` and the new `cur_pc` equal that next PC.
- R4: When `redir_valid` is 1 at acceptance, `redir_pc` becomes both `pkt_pc_wdata` and the new `cur_pc`. This holds for aligned and misaligned steps alike.
- R5: `pkt_order` holds the retirement count before the step. The count rises by one only for an aligned step with `dec_valid`=1.
- R6: `pkt_insn` is the whole 32-bit input word, zero-extended to 64 bits, for compressed words as well as full-length ones.
- R7: `rf_rs1_idx` is instruction bits 19:15 and `rf_rs2_idx` is bits 24:20, for every word. The packet carries both indices zero-extended to 8 bits, together with the read data present at acceptance.
- R8: While `irq_pending` is 1, `in_ready` is 0. No instruction is taken, and the PC and both counters keep their values.
- R9: An aligned step with `dec_valid`=0 sets `pkt_trap`. It advances the PC and the step counter but not the retirement counter.
- R10: `pkt_valid` stays 1 with a stable packet until `pkt_ready` is seen, and `in_ready` is 0 for as long as a packet is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmp_en | input | 1 | Compressed-instruction support enabled |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cur_pc | output | 64 | PC of the instruction to fetch |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Instruction word accepted this cycle when valid |
| in_insn | input | 32 | Instruction word |
| dec_valid | input | 1 | The word decodes to a legal instruction |
| redir_valid | input | 1 | Override the next PC |
| redir_pc | input | 64 | Override value for the next PC |
| rf_rs1_idx | output | 5 | Register-file read index, port 1 |
| rf_rs2_idx | output | 5 | Register-file read index, port 2 |
| rf_rs1_data | input | 64 | Register-file read data, port 1 |
| rf_rs2_data | input | 64 | Register-file read data, port 2 |
| pkt_valid | output | 1 | Trace packet available |
| pkt_ready | input | 1 | Trace packet consumed |
| pkt_order | output | 64 | Retirement order |
| pkt_pc_rdata | output | 64 | PC of the step |
| pkt_pc_wdata | output | 64 | PC after the step |
| pkt_insn | output | 64 | Instruction bits, zero-extended |
| pkt_rs1_addr | output | 8 | First source register address |
| pkt_rs2_addr | output | 8 | Second source register address |
| pkt_rs1_rdata | output | 64 | First source register value |
| pkt_rs2_rdata | output | 64 | Second source register value |
| pkt_trap | output | 1 | Step trapped (misaligned fetch or illegal instruction) |
| step_count | output | 64 | Steps taken |

## Verification
The register-file indices and `in_ready` are combinational, so they are valid in the same cycle the word or interrupt is presented. The bench samples them at the falling edge before the accepting rising edge. Every packet field, the new `cur_pc` and the counters change on the accepting rising edge, and the bench reads them at the next falling edge. `pkt_valid` drops on the rising edge where `pkt_ready` is high, and is checked at the falling edge after that. For the interrupt and back-pressure cases the bench holds the stimulus over several edges and checks at each falling edge that nothing has moved.

// File: rtl/step_trace_unit.sv
module step_trace_unit #(
  parameter int XLEN = 64,
  parameter int CNT_W = 64,
  parameter int PKT_INSN_W = 64,
  parameter int PKT_REG_W = 8,
  parameter logic [XLEN-1:0] RESET_PC = 64'h1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_cmp_en,
  input  logic                  irq_pending,
  output logic [XLEN-1:0]       cur_pc,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_insn,
  input  logic                  dec_valid,
  input  logic                  redir_valid,
  input  logic [XLEN-1:0]       redir_pc,
  output logic [4:0]            rf_rs1_idx,
  output logic [4:0]            rf_rs2_idx,
  input  logic [XLEN-1:0]       rf_rs1_data,
  input  logic [XLEN-1:0]       rf_rs2_data,
  output logic                  pkt_valid,
  input  logic                  pkt_ready,
  output logic [CNT_W-1:0]      pkt_order,
  output logic [XLEN-1:0]       pkt_pc_rdata,
  output logic [XLEN-1:0]       pkt_pc_wdata,
  output logic [PKT_INSN_W-1:0] pkt_insn,
  output logic [PKT_REG_W-1:0]  pkt_rs1_addr,
  output logic [PKT_REG_W-1:0]  pkt_rs2_addr,
  output logic [XLEN-1:0]       pkt_rs1_rdata,
  output logic [XLEN-1:0]       pkt_rs2_rdata,
  output logic                  pkt_trap,
  output logic [CNT_W-1:0]      step_count
);
  localparam int IDX_W = 5;

  logic [XLEN-1:0]  pc_q;
  logic [CNT_W-1:0] ret_q;
  logic [CNT_W-1:0] step_q;
  logic accept, misalign, is_full;
  logic [XLEN-1:0] seq_pc, next_pc;

  assign in_ready   = !pkt_valid && !irq_pending;
  assign accept     = in_valid && in_ready;
  assign misalign   = pc_q[0] | (pc_q[1] & ~cfg_cmp_en);
  assign is_full    = (in_insn[1:0] == 2'b11);
  assign seq_pc     = pc_q + {{(XLEN-3){1'b0}}, is_full, ~is_full, 1'b0};
  assign next_pc    = redir_valid ? redir_pc : (misalign ? pc_q : seq_pc);
  assign rf_rs1_idx = in_insn[19:15];
  assign rf_rs2_idx = in_insn[24:20];
  assign cur_pc     = pc_q;
  assign step_count = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q          <= RESET_PC;
      ret_q         <= '0;
      step_q        <= '0;
      pkt_valid     <= 1'b0;
      pkt_order     <= '0;
      pkt_pc_rdata  <= '0;
      pkt_pc_wdata  <= '0;
      pkt_insn      <= '0;
      pkt_rs1_addr  <= '0;
      pkt_rs2_addr  <= '0;
      pkt_rs1_rdata <= '0;
      pkt_rs2_rdata <= '0;
      pkt_trap      <= 1'b0;
    end else if (accept) begin
      pkt_valid    <= 1'b1;
      pkt_order    <= ret_q;
      pkt_pc_rdata <= pc_q;
      pkt_pc_wdata <= next_pc;
      pc_q         <= next_pc;
      pkt_trap     <= misalign | ~dec_valid;
      if (misalign) begin
        pkt_insn      <= '0;
        pkt_rs1_addr  <= '0;
        pkt_rs2_addr  <= '0;
        pkt_rs1_rdata <= '0;
        pkt_rs2_rdata <= '0;
      end else begin
        pkt_insn      <= {{(PKT_INSN_W-32){1'b0}}, in_insn};
        pkt_rs1_addr  <= {{(PKT_REG_W-IDX_W){1'b0}}, rf_rs1_idx};
        pkt_rs2_addr  <= {{(PKT_REG_W-IDX_W){1'b0}}, rf_rs2_idx};
        pkt_rs1_rdata <= rf_rs1_data;
        pkt_rs2_rdata <= rf_rs2_data;
        step_q        <= step_q + 1'b1;
        if (dec_valid) ret_q <= ret_q + 1'b1;
      end
    end else if (pkt_ready) begin
      pkt_valid <= 1'b0;
    end
  end

  a_r8_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> !in_ready);

  a_r10_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_pc_wdata)
                                   && $stable(pkt_order) && $stable(pkt_insn)));

  a_r2_no_step_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && misalign) |=> ($stable(step_count) && pkt_trap));

  a_r9_step_on_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !misalign) |=> (step_count == $past(step_count) + 1'b1));

  a_r3_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !misalign && !redir_valid) |=>
      (cur_pc == $past(cur_pc) + (($past(in_insn[1:0]) == 2'b11) ? 4 : 2)));

  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && redir_valid) |=> (cur_pc == $past(redir_pc)));
endmodule

// File: tb/tb_step_trace_unit.sv
module tb_step_trace_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cmp_en = 1'b1, irq_pending = 1'b0, in_valid = 1'b0, dec_valid = 1'b0;
  logic redir_valid = 1'b0, pkt_ready = 1'b0;
  logic [63:0] redir_pc = '0;
  logic [31:0] in_insn = '0;
  logic [63:0] cur_pc, rf_rs1_data, rf_rs2_data;
  logic [4:0] rf_rs1_idx, rf_rs2_idx;
  logic in_ready, pkt_valid, pkt_trap;
  logic [63:0] pkt_order, pkt_pc_rdata, pkt_pc_wdata, pkt_insn, pkt_rs1_rdata, pkt_rs2_rdata, step_count;
  logic [7:0] pkt_rs1_addr, pkt_rs2_addr;

  always #10 clk = ~clk;

  assign rf_rs1_data = 64'hC0DE_0000_0000_0000 | (64'(rf_rs1_idx) * 17);
  assign rf_rs2_data = 64'hBEEF_0000_0000_0000 | (64'(rf_rs2_idx) * 33);

  step_trace_unit dut (.*);

  int total = 0, fails = 0;
  logic [63:0] e_pc = 64'h1000, e_ret = 0, e_step = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic [31:0] w, input logic dv, input logic rv, input logic [63:0] rpc);
    logic mis = e_pc[0] | (e_pc[1] & ~cfg_cmp_en);
    logic full = (w[1:0] == 2'b11);
    logic [63:0] nxt = rv ? rpc : (mis ? e_pc : e_pc + (full ? 4 : 2));
    @(negedge clk);
    in_insn = w; dec_valid = dv; redir_valid = rv; redir_pc = rpc; in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R10 ready", 64'(in_ready), 64'd1);
    chk(rf_rs1_idx == w[19:15] && rf_rs2_idx == w[24:20], "R7 idx",
        {rf_rs1_idx, rf_rs2_idx}, {w[19:15], w[24:20]});
    @(negedge clk);
    in_valid = 1'b0; redir_valid = 1'b0;
    chk(pkt_valid == 1'b1, "R10 valid", 64'(pkt_valid), 64'd1);
    chk(pkt_pc_rdata == e_pc, "R2 pc_rdata", pkt_pc_rdata, e_pc);
    chk(pkt_pc_wdata == nxt && cur_pc == nxt, rv ? "R4 next" : "R3 next", pkt_pc_wdata, nxt);
    chk(pkt_order == e_ret, "R5 order", pkt_order, e_ret);
    chk(pkt_trap == (mis | ~dv), mis ? "R2 trap" : "R9 trap", 64'(pkt_trap), 64'(mis | ~dv));
    chk(pkt_insn == (mis ? 64'd0 : 64'(w)), "R6 insn", pkt_insn, mis ? 64'd0 : 64'(w));
    chk(pkt_rs1_addr == (mis ? 8'd0 : 8'(w[19:15])) && pkt_rs2_addr == (mis ? 8'd0 : 8'(w[24:20])),
        "R7 addr", {pkt_rs1_addr, pkt_rs2_addr}, mis ? 16'd0 : {8'(w[19:15]), 8'(w[24:20])});
    chk(pkt_rs1_rdata == (mis ? 64'd0 : (64'hC0DE_0000_0000_0000 | (64'(w[19:15]) * 17))),
        "R7 rs1 data", pkt_rs1_rdata, mis ? 64'd0 : (64'hC0DE_0000_0000_0000 | (64'(w[19:15]) * 17)));
    chk(pkt_rs2_rdata == (mis ? 64'd0 : (64'hBEEF_0000_0000_0000 | (64'(w[24:20]) * 33))),
        "R7 rs2 data", pkt_rs2_rdata, mis ? 64'd0 : (64'hBEEF_0000_0000_0000 | (64'(w[24:20]) * 33)));
    if (!mis) e_step++;
    if (!mis && dv) e_ret++;
    chk(step_count == e_step, mis ? "R2 step" : "R9 step", step_count, e_step);
    e_pc = nxt;
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk(pkt_valid == 1'b0, "R10 drop", 64'(pkt_valid), 64'd0);
  endtask

  localparam logic [35:0] VEC [0:7] = '{
    {32'h00C5_8533, 1'b1, 3'd4},
    {32'h0000_4501, 1'b1, 3'd2},
    {32'hFFFF_8082, 1'b1, 3'd2},
    {32'h01F0_00B3, 1'b0, 3'd4},
    {32'h1234_5676, 1'b0, 3'd2},
    {32'h0020_8093, 1'b1, 3'd4},
    {32'hABCD_EF00, 1'b1, 3'd2},
    {32'hFFFF_FFFF, 1'b1, 3'd4}
  };

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    chk(cur_pc == 64'h1000, "R1 pc", cur_pc, 64'h1000);
    chk(pkt_valid == 0 && pkt_trap == 0, "R1 valid", {pkt_valid, pkt_trap}, 0);
    chk(pkt_order == 0 && pkt_pc_rdata == 0 && pkt_pc_wdata == 0 && pkt_insn == 0,
        "R1 fields", pkt_insn, 0);
    chk(pkt_rs1_rdata == 0 && pkt_rs2_rdata == 0 && pkt_rs1_addr == 0 && pkt_rs2_addr == 0,
        "R1 regs", pkt_rs1_rdata, 0);
    chk(step_count == 0, "R1 step", step_count, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      do_step(VEC[i][35:4], VEC[i][3], 1'b0, 64'd0);
      chk(pkt_pc_wdata - pkt_pc_rdata == 64'(VEC[i][2:0]), "R3 length",
          pkt_pc_wdata - pkt_pc_rdata, 64'(VEC[i][2:0]));
    end

    do_step(32'h0000_0013, 1'b1, 1'b1, 64'h2001);
    do_step(32'h0031_01B3, 1'b1, 1'b0, 64'd0);
    do_step(32'h0031_01B3, 1'b1, 1'b1, 64'h3002);
    do_step(32'h0041_82B3, 1'b1, 1'b0, 64'd0);
    cfg_cmp_en = 1'b0;
    do_step(32'h0041_82B3, 1'b1, 1'b1, 64'h4000);
    do_step(32'h0041_82B3, 1'b1, 1'b0, 64'd0);
    cfg_cmp_en = 1'b1;

    @(negedge clk);
    irq_pending = 1'b1; in_valid = 1'b1; in_insn = 32'h0000_0013; dec_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(in_ready == 0, "R8 ready", 64'(in_ready), 0);
      @(negedge clk);
      chk(pkt_valid == 0 && cur_pc == e_pc && step_count == e_step, "R8 no take", cur_pc, e_pc);
    end
    in_valid = 1'b0; irq_pending = 1'b0;
    do_step(32'h0000_0013, 1'b1, 1'b0, 64'd0);

    @(negedge clk);
    in_insn = 32'h0000_0013; dec_valid = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk(pkt_valid == 1 && in_ready == 0, "R10 hold", {pkt_valid, in_ready}, 2'b10);
      chk(pkt_order == e_ret, "R10 stable", pkt_order, e_ret);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(cur_pc == e_pc + 4, "R10 single take", cur_pc, e_pc + 4);
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk(pkt_valid == 0, "R10 release", 64'(pkt_valid), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule